// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers a group of interrupt source lines into one register bank and forwards them to a downstream interrupt controller. Each source sets a sticky status bit. Software enables or masks sources through two write ports, one that sets enable bits and one that clears them. A read-only result register shows which sources are both pending and enabled.

A global mode input selects how the pending-and-enabled bits leave the block. In direct mode, each bit drives its own output line. In aggregated mode, all bits are ORed onto a single group line.

The bank sits on a simple register bus. The bus has a byte address, a write strobe and write data. Read data is combinational from the address. The block has no state machine: all of its state is the status vector and the enable vector.

Top module: `gia_top`

## Requirements
- R1: A synchronous reset clears every status and enable bit, so `irq_direct`, `irq_group` and every register read are zero after reset.
- R2: A source bit that is high at a rising clock edge sets its status bit at that edge. The bit then stays set while the source is low.
- R3: A write to byte offset 0x0 clears every status bit whose data bit is 1. Data bits that are 0 leave status unchanged. A read at 0x0 returns the status vector.
- R4: A write to byte offset 0x4 sets every enable bit whose data bit is 1, and 0 bits leave enables unchanged. A read at 0x4 returns the enable vector.
- R5: A write to byte offset 0xC clears every enable bit whose data bit is 1, and 0 bits leave enables unchanged. A read at 0xC returns the enable vector.
- R6: A read at byte offset 0x8 returns status AND enable. A write to 0x8 changes neither status nor enable.
- R7: With `direct_mode` = 1, `irq_direct` equals status AND enable, bit for bit, and `irq_group` is 0.
- R8: With `direct_mode` = 0, `irq_group` is the OR of all status-AND-enable bits, and `irq_direct` is all zero.
- R9: A source that is high in the same cycle as a status clear write to its bit leaves that status bit set.
- R10: An access whose address has bit 1 or bit 0 set has no effect on any register, and a read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src | input | NUM_SRC | Interrupt source levels, sampled each clock |
| direct_mode | input | 1 | 1 = one output line per bit, 0 = single ORed line |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for `bus_addr` |
| irq_direct | output | NUM_SRC | Per-bit interrupt lines (direct mode) |
| irq_group | output | 1 | Group interrupt line (aggregated mode) |

## Verification
The bench builds the block with its default of 32 sources and a 4-bit address. With this width, the lowest and highest bits (0 and 31) can be exercised together, which exposes any truncation or off-by-one in the per-bit generate loops. The 4-bit address makes all four aligned offsets and the unaligned offsets reachable. Both output modes are run against the same register state, and the set-versus-clear collision is driven in a single cycle.

// File: rtl/gia_pkg.sv
package gia_pkg;

    // Word selector taken from address bits [3:2]
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_RESULT = 2'd2,
        SEL_EN_CLR = 2'd3
    } gia_sel_e;

    typedef struct packed {
        logic stat_clr;
        logic en_set;
        logic en_clr;
        logic hit;
    } gia_strobe_t;

endpackage

// File: rtl/gia_status_bank.sv
module gia_status_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] status_q
);

    // One sticky cell per source; a new event beats a same-cycle clear.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[i] <= 1'b0;
            end else if (src[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    // R2: every source seen high is pending one edge later
    p_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (src != '0) |=> ((status_q & $past(src)) == $past(src)));

    // R3: a status bit only falls when a clear was requested for it
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0));

endmodule

// File: rtl/gia_enable_bank.sv
module gia_enable_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_mask,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] enable_q
);

    logic [NUM_SRC-1:0] enable_d;

    always_comb begin
        enable_d = (enable_q | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else begin
            enable_q <= enable_d;
        end
    end

    // R4: bits named by a set write are on afterwards
    p_en_set_r4: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((enable_q & $past(set_mask)) == $past(set_mask)));

    // R5: bits named by a clear write are off afterwards
    p_en_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((enable_q & $past(clr_mask)) == '0));

    // R6: with no port write, the enable vector holds
    p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (set_mask == '0 && clr_mask == '0) |=> $stable(enable_q));

endmodule

// File: rtl/gia_router.sv
module gia_router #(
    parameter int NUM_SRC = 32
) (
    input  logic               direct_mode,
    input  logic [NUM_SRC-1:0] status_q,
    input  logic [NUM_SRC-1:0] enable_q,
    output logic [NUM_SRC-1:0] result,
    output logic [NUM_SRC-1:0] irq_direct,
    output logic               irq_group
);

    always_comb begin
        result = status_q & enable_q;
        if (direct_mode) begin
            irq_direct = result;
            irq_group  = 1'b0;
        end else begin
            irq_direct = '0;
            irq_group  = |result;
        end
    end

endmodule

// File: rtl/gia_top.sv
module gia_top #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  logic               direct_mode,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic [NUM_SRC-1:0] irq_direct,
    output logic               irq_group
);
    import gia_pkg::*;

    localparam int HI_W = ADDR_W - 4;

    gia_sel_e           sel;
    gia_strobe_t        stb;
    logic               aligned;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] result;
    logic [NUM_SRC-1:0] stat_clr_mask;
    logic [NUM_SRC-1:0] en_set_mask;
    logic [NUM_SRC-1:0] en_clr_mask;

    // Address decode: only aligned words inside the 16-byte window hit
    if (ADDR_W > 4) begin : g_wide
        always_comb aligned = (bus_addr[1:0] == 2'b00) &&
                              (bus_addr[ADDR_W-1:4] == {HI_W{1'b0}});
    end else begin : g_narrow
        always_comb aligned = (bus_addr[1:0] == 2'b00);
    end

    always_comb begin
        sel          = gia_sel_e'(bus_addr[3:2]);
        stb          = '0;
        stb.hit      = aligned;
        if (bus_wr && aligned) begin
            unique case (sel)
                SEL_STATUS: stb.stat_clr = 1'b1;
                SEL_EN_SET: stb.en_set   = 1'b1;
                SEL_EN_CLR: stb.en_clr   = 1'b1;
                SEL_RESULT: ;
            endcase
        end
        stat_clr_mask = stb.stat_clr ? bus_wdata : '0;
        en_set_mask   = stb.en_set   ? bus_wdata : '0;
        en_clr_mask   = stb.en_clr   ? bus_wdata : '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (stb.hit) begin
            unique case (sel)
                SEL_STATUS: bus_rdata = status_q;
                SEL_EN_SET: bus_rdata = enable_q;
                SEL_RESULT: bus_rdata = result;
                SEL_EN_CLR: bus_rdata = enable_q;
            endcase
        end
    end

    gia_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .clr_mask (stat_clr_mask),
        .status_q (status_q)
    );

    gia_enable_bank #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .set_mask (en_set_mask),
        .clr_mask (en_clr_mask),
        .enable_q (enable_q)
    );

    gia_router #(.NUM_SRC(NUM_SRC)) u_route (
        .direct_mode (direct_mode),
        .status_q    (status_q),
        .enable_q    (enable_q),
        .result      (result),
        .irq_direct  (irq_direct),
        .irq_group   (irq_group)
    );

    // R7: no per-bit line rises without a pending enabled source
    p_direct_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_direct & ~(status_q & enable_q)) == '0);

    // R8: the group line implies some pending enabled source, and in direct mode it is low
    p_group_r8: assert property (@(posedge clk) disable iff (rst)
        irq_group |-> (!direct_mode && ((status_q & enable_q) != '0)));

    // R9: a source high during a clear of its bit still leaves it pending
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ((src & stat_clr_mask) != '0) |=>
            ((status_q & $past(src & stat_clr_mask)) == $past(src & stat_clr_mask)));

    // R1: right after reset nothing is pending or enabled
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (status_q == '0 && enable_q == '0));

    // R10: unaligned writes leave both vectors untouched
    p_unaligned_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[1:0] != 2'b00 && src == '0) |=>
            ($stable(status_q) && $stable(enable_q)));

endmodule

// File: tb/tb_gia_top.sv
module tb_gia_top;
    localparam int N = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src = '0;
    logic          direct_mode = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  irq_direct;
    logic          irq_group;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    gia_top #(.NUM_SRC(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .src(src), .direct_mode(direct_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_direct(irq_direct), .irq_group(irq_group)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
        src = '0;
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        rd(4'h0, v); check("R1 status", v, '0);
        rd(4'h4, v); check("R1 enable", v, '0);
        check("R1 direct", irq_direct, '0);
        check("R1 group", {31'b0, irq_group}, '0);
    endtask

    task automatic t_latch();
        logic [N-1:0] v;
        pulse(32'h8000_0001);
        #2;
        rd(4'h0, v); check("R2 latch", v, 32'h8000_0001);
        rd(4'h8, v); check("R6 result masked", v, '0);
        check("R8 group idle", {31'b0, irq_group}, '0);
    endtask

    task automatic t_enable_modes();
        logic [N-1:0] v;
        wr(4'h4, 32'h0000_0001);
        rd(4'h4, v); check("R4 set", v, 32'h1);
        rd(4'h8, v); check("R6 result", v, 32'h1);
        check("R8 group", {31'b0, irq_group}, 32'h1);
        check("R8 direct low", irq_direct, '0);
        direct_mode = 1'b1; #1;
        check("R7 direct", irq_direct, 32'h1);
        check("R7 group low", {31'b0, irq_group}, '0);
        wr(4'h4, 32'h8000_0000);
        rd(4'h4, v); check("R4 zeros keep", v, 32'h8000_0001);
        check("R7 direct both", irq_direct, 32'h8000_0001);
    endtask

    task automatic t_result_ro();
        logic [N-1:0] v;
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R6 ro status", v, 32'h8000_0001);
        rd(4'h4, v); check("R6 ro enable", v, 32'h8000_0001);
    endtask

    task automatic t_w1c();
        logic [N-1:0] v;
        wr(4'h0, 32'h0);
        rd(4'h0, v); check("R3 zero write", v, 32'h8000_0001);
        wr(4'h0, 32'h1);
        rd(4'h0, v); check("R3 w1c", v, 32'h8000_0000);
        check("R7 after clear", irq_direct, 32'h8000_0000);
    endtask

    task automatic t_en_clear();
        logic [N-1:0] v;
        wr(4'hC, 32'h8000_0000);
        rd(4'hC, v); check("R5 clear", v, 32'h1);
        check("R5 direct off", irq_direct, '0);
    endtask

    task automatic t_set_wins();
        logic [N-1:0] v;
        @(negedge clk);
        src = 32'h20; bus_addr = 4'h0; bus_wdata = 32'h20; bus_wr = 1'b1;
        @(negedge clk);
        src = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd(4'h0, v); check("R9 set wins", v, 32'h8000_0020);
    endtask

    task automatic t_aggregate();
        direct_mode = 1'b0; #1;
        check("R8 no enabled pending", {31'b0, irq_group}, '0);
        wr(4'h4, 32'h20);
        check("R8 group on", {31'b0, irq_group}, 32'h1);
        check("R8 direct zero", irq_direct, '0);
    endtask

    task automatic t_unaligned();
        logic [N-1:0] v;
        wr(4'h5, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R10 enable kept", v, 32'h21);
        rd(4'h0, v); check("R10 status kept", v, 32'h8000_0020);
        rd(4'h1, v); check("R10 read zero", v, '0);
    endtask

    task automatic t_rereset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_latch();
                t_enable_modes();
                t_result_ro();
                t_w1c();
                t_en_clear();
                t_set_wins();
                t_aggregate();
                t_unaligned();
                t_rereset();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule